// File: doc/BRIEF.md
# Receive Byte Ring with In-Band Pause and Resume

This block sits between a serial receiver and whatever consumes the received bytes. Each byte offered on the write side goes into a circular store, and the consumer takes bytes from the read side in arrival order. The read side shows the oldest byte, a flag that says a byte is waiting, and the current fill count. When the store is full, a new byte is thrown away and a sticky overflow flag is raised. Stored bytes are never overwritten.

The block watches its own fill level and drives flow control with two thresholds that give hysteresis. When the fill rises above the upper mark, it raises a one-cycle request for the local transmitter to send the pause character (0x13) and records that the far end is paused. When the fill later drops below the lower mark, it raises a one-cycle request to send the resume character (0x11) and clears that record. There is one request per crossing.

A separate, optional watcher looks at control bytes coming from the far end. When it sees the pause character, it holds the outgoing stream. When it sees the resume character, it lets the stream go again. Turning bytes into serial bits is not part of this block.

Top module: `rx_flow_buffer`

## Requirements
- R1: After a synchronous active-low reset the store is empty: `fill_count` is 0, and `byte_avail`, `overflow`, `req_pause`, `req_resume`, `far_paused` and `tx_hold` are all 0.
- R2: `rd_byte` always shows the oldest stored byte. Bytes leave in the order they were accepted, including after the indices wrap around the end of the store.
- R3: `fill_count` rises by one on an accepted write and falls by one on a read of a non-empty store. A write and a read in the same cycle leave it unchanged when the store is neither empty nor full. `byte_avail` is 1 exactly when `fill_count` is above zero.
- R4: A write that arrives while `fill_count` equals DEPTH is discarded, even when a read happens in the same cycle. The stored bytes are left as they were.
- R5: A discarded write sets `overflow` from the next cycle on. `ovf_clear` clears it, but a discard in the same cycle as a clear wins.
- R6: A read while the store is empty has no effect: `fill_count` stays 0.
- R7: If `far_paused` is 0 and `fill_count` is above HIGH_MARK, then on the next cycle `req_pause` pulses for one cycle, `flow_char` shows 0x13, and `far_paused` becomes 1.
- R8: If `far_paused` is 1 and `fill_count` is below LOW_MARK, then on the next cycle `req_resume` pulses for one cycle, `flow_char` shows 0x11, and `far_paused` becomes 0.
- R9: Only one request is made per threshold crossing. While the fill stays above LOW_MARK after a pause, no further pause request is made, and the two requests never occur in the same cycle.
- R10: With the watcher enabled, a `peer_valid` byte of 0x13 sets `tx_hold` on the next cycle, a byte of 0x11 clears it, and any other byte leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | A received byte is offered this cycle |
| wr_byte | input | 8 | Received byte |
| rd_take | input | 1 | Consumer takes the oldest byte |
| rd_byte | output | 8 | Oldest stored byte |
| byte_avail | output | 1 | At least one byte is stored |
| fill_count | output | $clog2(DEPTH+1) | Number of stored bytes |
| overflow | output | 1 | Sticky flag: a byte was discarded |
| ovf_clear | input | 1 | Clears the overflow flag |
| req_pause | output | 1 | One-cycle request to send the pause character |
| req_resume | output | 1 | One-cycle request to send the resume character |
| flow_char | output | 8 | Character belonging to the latest request |
| far_paused | output | 1 | The far end has been asked to pause |
| peer_valid | input | 1 | A control byte from the far end is present |
| peer_byte | input | 8 | Control byte from the far end |
| tx_hold | output | 1 | Outgoing stream is held by the far end |

## Verification
The bench builds the block with DEPTH 8, HIGH_MARK 5 and LOW_MARK 2. At these values, filling to full, discarding writes, and wrapping the indices all take only a handful of cycles. The hysteresis band is three bytes wide, so the bench can move the fill back and forth inside the band and show that no extra requests appear. The default depth uses the same logic with wider counters and indices.

// File: rtl/rxfb_pkg.sv
// Shared byte type and the default in-band flow characters.
package rxfb_pkg;
    typedef logic [7:0] byte_t;
    localparam byte_t CHAR_PAUSE  = 8'h13;
    localparam byte_t CHAR_RESUME = 8'h11;
endpackage

// File: rtl/rxfb_ring.sv
// Circular byte store with head/tail indices and a fill counter.
// Assumes DEPTH >= 2. Reads are combinational from the head slot.
// A write is dropped whenever the store is full, even if a read
// happens in the same cycle.
module rxfb_ring
    import rxfb_pkg::*;
#(
    parameter int DEPTH = 4096
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_valid,
    input  byte_t                        wr_byte,
    input  logic                         rd_take,
    output byte_t                        rd_byte,
    output logic [$clog2(DEPTH+1)-1:0]   fill_count,
    output logic                         drop
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    byte_t             store [DEPTH];
    logic [PTR_W-1:0]  head_q, tail_q;
    logic [CNT_W-1:0]  count_q, count_d;
    logic              is_full, is_empty, push, pop;

    // Decide whether this cycle's write is accepted and whether the read pops.
    always_comb begin
        is_full  = (count_q == FULL_CNT);
        is_empty = (count_q == '0);
        push     = wr_valid && !is_full;
        pop      = rd_take && !is_empty;
        drop     = wr_valid && is_full;
    end

    // Work out the next fill count from the push/pop pair.
    always_comb begin
        unique case ({push, pop})
            2'b10:   count_d = count_q + CNT_W'(1);
            2'b01:   count_d = count_q - CNT_W'(1);
            default: count_d = count_q;
        endcase
    end

    // Move the indices and the counter, wrapping at the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            if (push) tail_q <= (tail_q == LAST_IDX) ? '0 : tail_q + PTR_W'(1);
            if (pop)  head_q <= (head_q == LAST_IDX) ? '0 : head_q + PTR_W'(1);
            count_q <= count_d;
        end
    end

    // Write an accepted byte into the tail slot.
    always_ff @(posedge clk) begin
        if (push) store[tail_q] <= wr_byte;
    end

    assign rd_byte    = store[head_q];
    assign fill_count = count_q;

    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill_count <= FULL_CNT);
    a_r3_pair_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && rd_take && fill_count != '0 && fill_count != FULL_CNT)
        |=> $stable(fill_count));
    a_r4_full_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_count == FULL_CNT && !rd_take) |=> fill_count == FULL_CNT);
    a_r6_empty_read_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_count == '0 && rd_take && !wr_valid) |=> fill_count == '0);
endmodule

// File: rtl/rxfb_flow.sv
// Hysteresis controller: compares the registered fill count against
// two marks and issues one pause or resume request per crossing.
// Assumes LOW_MARK < HIGH_MARK <= DEPTH.
module rxfb_flow
    import rxfb_pkg::*;
#(
    parameter int    CNT_W       = 13,
    parameter int    HIGH_MARK   = 3072,
    parameter int    LOW_MARK    = 1024,
    parameter byte_t PAUSE_CODE  = CHAR_PAUSE,
    parameter byte_t RESUME_CODE = CHAR_RESUME
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  fill_count,
    output logic              req_pause,
    output logic              req_resume,
    output byte_t             flow_char,
    output logic              far_paused
);
    localparam logic [CNT_W-1:0] HIGH_C = CNT_W'(HIGH_MARK);
    localparam logic [CNT_W-1:0] LOW_C  = CNT_W'(LOW_MARK);

    // Track the pause state and pulse a request on each crossing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            far_paused <= 1'b0;
            req_pause  <= 1'b0;
            req_resume <= 1'b0;
            flow_char  <= RESUME_CODE;
        end else begin
            req_pause  <= 1'b0;
            req_resume <= 1'b0;
            if (!far_paused && fill_count > HIGH_C) begin
                far_paused <= 1'b1;
                req_pause  <= 1'b1;
                flow_char  <= PAUSE_CODE;
            end else if (far_paused && fill_count < LOW_C) begin
                far_paused <= 1'b0;
                req_resume <= 1'b1;
                flow_char  <= RESUME_CODE;
            end
        end
    end

    a_r7_pause_sets_state: assert property (@(posedge clk) disable iff (!rst_n)
        req_pause |-> (far_paused && flow_char == PAUSE_CODE));
    a_r8_resume_clears_state: assert property (@(posedge clk) disable iff (!rst_n)
        req_resume |-> (!far_paused && flow_char == RESUME_CODE));
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        req_pause |=> !req_pause);
    a_r9_never_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_pause && req_resume));
endmodule

// File: rtl/rxfb_peer_watch.sv
// Watches control bytes from the far end and holds the outgoing
// stream between a pause character and the next resume character.
module rxfb_peer_watch
    import rxfb_pkg::*;
#(
    parameter byte_t PAUSE_CODE  = CHAR_PAUSE,
    parameter byte_t RESUME_CODE = CHAR_RESUME
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  peer_valid,
    input  byte_t peer_byte,
    output logic  tx_hold
);
    // Latch the hold state from recognised control characters.
    always_ff @(posedge clk) begin
        if (!rst_n)                                      tx_hold <= 1'b0;
        else if (peer_valid && peer_byte == PAUSE_CODE)  tx_hold <= 1'b1;
        else if (peer_valid && peer_byte == RESUME_CODE) tx_hold <= 1'b0;
    end

    a_r10_pause_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (peer_valid && peer_byte == PAUSE_CODE) |=> tx_hold);
    a_r10_other_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (peer_valid && peer_byte != PAUSE_CODE && peer_byte != RESUME_CODE)
        |=> $stable(tx_hold));
endmodule

// File: rtl/rx_flow_buffer.sv
// Receive buffer top: ring store, sticky overflow flag, fill-level
// flow control and an optional watcher for the far end's control bytes.
// Assumes one byte per cycle at most on each side.
module rx_flow_buffer
    import rxfb_pkg::*;
#(
    parameter int    DEPTH       = 4096,
    parameter int    HIGH_MARK   = 3072,
    parameter int    LOW_MARK    = 1024,
    parameter byte_t PAUSE_CODE  = CHAR_PAUSE,
    parameter byte_t RESUME_CODE = CHAR_RESUME,
    parameter bit    PEER_WATCH  = 1'b1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_valid,
    input  logic [7:0]                  wr_byte,
    input  logic                        rd_take,
    output logic [7:0]                  rd_byte,
    output logic                        byte_avail,
    output logic [$clog2(DEPTH+1)-1:0]  fill_count,
    output logic                        overflow,
    input  logic                        ovf_clear,
    output logic                        req_pause,
    output logic                        req_resume,
    output logic [7:0]                  flow_char,
    output logic                        far_paused,
    input  logic                        peer_valid,
    input  logic [7:0]                  peer_byte,
    output logic                        tx_hold
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic drop;

    rxfb_ring #(.DEPTH(DEPTH)) u_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid   (wr_valid),
        .wr_byte    (wr_byte),
        .rd_take    (rd_take),
        .rd_byte    (rd_byte),
        .fill_count (fill_count),
        .drop       (drop)
    );

    rxfb_flow #(
        .CNT_W       (CNT_W),
        .HIGH_MARK   (HIGH_MARK),
        .LOW_MARK    (LOW_MARK),
        .PAUSE_CODE  (PAUSE_CODE),
        .RESUME_CODE (RESUME_CODE)
    ) u_flow (
        .clk        (clk),
        .rst_n      (rst_n),
        .fill_count (fill_count),
        .req_pause  (req_pause),
        .req_resume (req_resume),
        .flow_char  (flow_char),
        .far_paused (far_paused)
    );

    generate
        if (PEER_WATCH) begin : g_peer
            rxfb_peer_watch #(
                .PAUSE_CODE  (PAUSE_CODE),
                .RESUME_CODE (RESUME_CODE)
            ) u_peer (
                .clk        (clk),
                .rst_n      (rst_n),
                .peer_valid (peer_valid),
                .peer_byte  (peer_byte),
                .tx_hold    (tx_hold)
            );
        end else begin : g_no_peer
            logic unused_peer;
            assign unused_peer = peer_valid ^ (^peer_byte);
            assign tx_hold     = 1'b0;
        end
    endgenerate

    assign byte_avail = (fill_count != '0);

    // Sticky overflow: a discard sets it and takes priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         overflow <= 1'b0;
        else if (drop)      overflow <= 1'b1;
        else if (ovf_clear) overflow <= 1'b0;
    end

    a_r5_discard_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && fill_count == CNT_W'(DEPTH)) |=> overflow);
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !ovf_clear) |=> overflow);
endmodule

// File: tb/test_rx_flow_buffer.sv
`timescale 1ns/1ps
module test_rx_flow_buffer;
    localparam int DEPTH = 8;
    localparam int HIGH  = 5;
    localparam int LOW   = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0, rd_take = 1'b0, ovf_clear = 1'b0, peer_valid = 1'b0;
    logic [7:0] wr_byte = '0, peer_byte = '0;
    logic [7:0] rd_byte, flow_char;
    logic [3:0] fill_count;
    logic       byte_avail, overflow, req_pause, req_resume, far_paused, tx_hold;

    int n_checks = 0;
    int n_fail   = 0;

    // reference model state
    byte unsigned m_q[$];
    bit  m_ovf, m_pause_req, m_resume_req, m_paused, m_hold;
    byte unsigned m_char;

    always #2.5 clk = ~clk;

    rx_flow_buffer #(.DEPTH(DEPTH), .HIGH_MARK(HIGH), .LOW_MARK(LOW)) i_rx_flow_buffer (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_byte(wr_byte),
        .rd_take(rd_take), .rd_byte(rd_byte), .byte_avail(byte_avail),
        .fill_count(fill_count), .overflow(overflow), .ovf_clear(ovf_clear),
        .req_pause(req_pause), .req_resume(req_resume), .flow_char(flow_char),
        .far_paused(far_paused), .peer_valid(peer_valid), .peer_byte(peer_byte),
        .tx_hold(tx_hold)
    );

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_q.delete();
            m_ovf = 0; m_pause_req = 0; m_resume_req = 0; m_paused = 0;
            m_hold = 0; m_char = 8'h11;
        end else begin
            int cnt;
            cnt = m_q.size();
            m_pause_req = 0; m_resume_req = 0;
            if (!m_paused && cnt > HIGH) begin
                m_paused = 1; m_pause_req = 1; m_char = 8'h13;
            end else if (m_paused && cnt < LOW) begin
                m_paused = 0; m_resume_req = 1; m_char = 8'h11;
            end
            if (wr_valid && cnt == DEPTH) m_ovf = 1;
            else if (ovf_clear)           m_ovf = 0;
            if (rd_take && cnt > 0) void'(m_q.pop_front());
            if (wr_valid && cnt < DEPTH) m_q.push_back(wr_byte);
            if (peer_valid && peer_byte == 8'h13)      m_hold = 1;
            else if (peer_valid && peer_byte == 8'h11) m_hold = 0;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R3 fill_count", fill_count, m_q.size());
        chk("R3 byte_avail", byte_avail, m_q.size() > 0);
        if (m_q.size() > 0) chk("R2 rd_byte order", rd_byte, m_q[0]);
        chk("R5 overflow", overflow, m_ovf);
        chk("R7 req_pause", req_pause, m_pause_req);
        chk("R8 req_resume", req_resume, m_resume_req);
        chk("R9 far_paused", far_paused, m_paused);
        if (m_pause_req || m_resume_req) chk("R7 R8 flow_char", flow_char, m_char);
        chk("R10 tx_hold", tx_hold, m_hold);
    endtask

    // one clock: inputs were set at a falling edge, compare at the next one
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic drive(input bit w, input byte unsigned d, input bit r, input bit c);
        wr_valid = w; wr_byte = d; rd_take = r; ovf_clear = c;
        step();
        wr_valid = 0; rd_take = 0; ovf_clear = 0;
    endtask

    task automatic peer(input byte unsigned d);
        peer_valid = 1; peer_byte = d;
        step();
        peer_valid = 0;
    endtask

    int pulses;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 count", fill_count, 0);
        chk("R1 avail", byte_avail, 0);
        chk("R1 flags", {overflow, req_pause, req_resume, far_paused, tx_hold}, 0);

        // R6: read on empty
        drive(0, 0, 1, 0);
        chk("R6 empty read", fill_count, 0);

        // fill past the high mark: R7 pulse expected
        for (int i = 0; i < 6; i++) drive(1, 8'hA0 + i, 0, 0);
        drive(0, 0, 0, 0);
        chk("R9 paused after crossing", far_paused, 1);
        // fill to full, then two discards: R4, R5
        drive(1, 8'hB0, 0, 0);
        drive(1, 8'hB1, 0, 0);
        chk("R4 full", fill_count, DEPTH);
        drive(1, 8'hEE, 0, 0);
        drive(1, 8'hEF, 0, 0);
        chk("R4 no growth", fill_count, DEPTH);
        chk("R4 head intact", rd_byte, 8'hA0);
        chk("R5 overflow set", overflow, 1);
        drive(0, 0, 0, 1);
        chk("R5 cleared", overflow, 0);
        // discard and clear in the same cycle: discard wins
        drive(1, 8'hEA, 0, 1);
        chk("R5 discard wins", overflow, 1);
        // full with read and write: write dropped, count falls
        drive(1, 8'hEB, 1, 1);
        chk("R4 full read+write", fill_count, DEPTH - 1);
        // paired read and write mid-range: R3
        drive(1, 8'hC0, 1, 0);
        chk("R3 paired keeps count", fill_count, DEPTH - 1);

        // drain inside the band: no extra pause request (R9)
        pulses = 0;
        for (int i = 0; i < 5; i++) begin
            drive(0, 0, 1, 0);
            if (req_pause) pulses++;
        end
        chk("R9 no repeat pause", pulses, 0);
        // down below the low mark: R8 pulse
        for (int i = 0; i < 4; i++) drive(0, 0, 1, 0);
        drive(0, 0, 0, 0);
        chk("R8 resumed", far_paused, 0);
        drive(0, 0, 1, 0);
        chk("R6 drained", fill_count, 0);

        // wrap-around traffic with mixed patterns: R2, R3
        for (int i = 0; i < 30; i++)
            drive((i % 3) != 2, 8'h10 + i, (i % 4) == 3, 0);
        for (int i = 0; i < 12; i++) drive(0, 0, 1, 0);

        // far-end control bytes: R10
        peer(8'h41);
        chk("R10 other ignored", tx_hold, 0);
        peer(8'h13);
        chk("R10 pause", tx_hold, 1);
        peer(8'h55);
        chk("R10 other keeps hold", tx_hold, 1);
        peer(8'h11);
        chk("R10 resume", tx_hold, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(5 * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule